// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits behind the bus pins of a parallel NOR flash and decides which host writes become array operations. Each qualified write strobe is reduced to a single write event carrying the address and the 16-bit data. A small state machine then matches these events against the unlock sequences that guard array changes. A program needs a three-write command preamble and then one address/data write. Sector, block and whole-chip erase need a six-write sequence. A write that breaks a sequence drops the machine back to read mode and flags an abort.

Accepted operations leave as one-cycle start pulses with the target address (and data or erase kind). A write-protect guard vetoes any operation that would touch the top 32 KWord boot region while the protect pin is low. The unlock addresses, command bytes, boot region and strobe filter length are all parameters. The bench uses the common example set: 0x5555/0xAA, 0x2AAA/0x55, 0xA0 for program, 0x80 for erase, and 0x50/0x30/0x10 for sector/block/chip.

Top module: `flash_unlock_seq`

## Requirements
- R1: After writes (0x5555, 0xAA), (0x2AAA, 0x55) and (0x5555, 0xA0), the next accepted write raises `prog_start` for one cycle, with `prog_addr`/`prog_data` equal to that write's address and full 16-bit data.
- R2: After (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), a sixth write raises `erase_start` for one cycle. Data 0x50 at any address gives `erase_kind`=0 (sector). Data 0x30 gives kind 1 (block). Data 0x10 at 0x5555 gives kind 2 (chip). `erase_addr` is the sixth write's address.
- R3: Once the first unlock write has been taken, any write that does not match the next expected step pulses `abort` for one cycle and returns to idle, so a new sequence must begin again from its first write. A non-matching write in idle is ignored without abort.
- R4: During command writes only data bits 7:0 are compared; bits 15:8 may hold any value.
- R5: With `wp_n` low, a program or sector/block erase whose address lies in 0xF8000–0xFFFFF, and any chip erase, produces no start pulse and no abort, and the machine returns to idle. With `wp_n` high these operations are accepted.
- R6: A write is not taken while `oe_n` is low, `ce_n` is high, `we_n` is high or `vdd_ok` is low.
- R7: A low level on `flash_rst_n` abandons any partial sequence without any pulse, even when it coincides with the write that would complete an operation.
- R8: A strobe active for fewer than MIN_PULSE (3) consecutive clocks is ignored. A strobe of MIN_PULSE or more clocks counts as exactly one write, whatever its length.
- R9: After `rst`, all start pulses, abort and latched outputs are zero.
- R10: `prog_start` and `erase_start` are never high in the same cycle and never stay high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flash_rst_n | input | 1 | Active-low device reset pin, returns to read mode |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low (low inhibits writes) |
| addr | input | 20 | Word address |
| wdata | input | 16 | Write data |
| wp_n | input | 1 | Boot region write protect, active low |
| vdd_ok | input | 1 | Supply good flag |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 16 | Program data |
| erase_start | output | 1 | One-cycle erase start |
| erase_kind | output | 2 | 0 sector, 1 block, 2 chip |
| erase_addr | output | 20 | Erase target address |
| abort | output | 1 | One-cycle sequence abort |

## Verification
The device reset pin and the write that completes an operation can land in the same cycle. The filtered write event is already registered and on its way into the sequencer when reset falls. The bench provokes this by holding the final program strobe past the filter length and then lowering `flash_rst_n` in the cycle the event is handed to the sequencer. It judges the result by seeing neither a start pulse nor an abort, and by a following complete sequence that works from its first write. Random mixes of program, erase and broken sequences, with random protect levels and addresses biased into the boot region, are compared against pulse counts and latched values predicted by bench functions.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  typedef enum logic [1:0] {
    ER_SECTOR = 2'd0,
    ER_BLOCK  = 2'd1,
    ER_CHIP   = 2'd2
  } erase_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_U1,
    S_U2,
    S_PROG,
    S_E3,
    S_E4,
    S_E5
  } fcu_state_e;
endpackage

// File: rtl/fcu_strobe_filter.sv
module fcu_strobe_filter #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              vdd_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_PULSE);

  logic          strobe;
  logic [CW-1:0] cnt;
  logic          hit;

  assign strobe = ~ce_n & ~we_n & oe_n & vdd_ok;
  assign hit    = strobe && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= hit;
      if (!strobe)
        cnt <= '0;
      else if (cnt != FULL)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_addr <= '0;
      evt_data <= '0;
    end else if (hit) begin
      evt_addr <= addr;
      evt_data <= wdata;
    end
  end

  assert_one_evt_per_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
  assert_inhibit_no_evt_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe) |-> !evt);
endmodule

// File: rtl/fcu_boot_guard.sv
module fcu_boot_guard #(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 20'hF8000,
  parameter int                BOOT_LOG2 = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              whole_chip,
  output logic              blocked
);
  localparam int TAG_W = ADDR_W - BOOT_LOG2;
  localparam logic [TAG_W-1:0] BOOT_TAG = BOOT_BASE[ADDR_W-1:BOOT_LOG2];

  logic in_boot;
  assign in_boot = (addr[ADDR_W-1:BOOT_LOG2] == BOOT_TAG);
  assign blocked = ~wp_n & (in_boot | whole_chip);
endmodule

// File: rtl/fcu_unlock_fsm.sv
module fcu_unlock_fsm
  import fcu_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 20'h05555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 20'h02AAA,
  parameter logic [7:0]        KEY1      = 8'hAA,
  parameter logic [7:0]        KEY2      = 8'h55,
  parameter logic [7:0]        OP_PROG   = 8'hA0,
  parameter logic [7:0]        OP_ERASE  = 8'h80,
  parameter logic [7:0]        OP_SECT   = 8'h50,
  parameter logic [7:0]        OP_BLK    = 8'h30,
  parameter logic [7:0]        OP_CHIP   = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              blocked,
  output logic              whole_chip,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_start,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              abort
);
  fcu_state_e  state, nxt;
  logic [7:0]  low;
  logic        at_a1, hit1, hit2;
  logic        go_prog, go_erase, bad;
  erase_kind_e kind;

  assign low   = evt_data[7:0];
  assign at_a1 = (evt_addr == UNLOCK_A1);
  assign hit1  = at_a1 && (low == KEY1);
  assign hit2  = (evt_addr == UNLOCK_A2) && (low == KEY2);

  always_comb begin
    nxt        = state;
    go_prog    = 1'b0;
    go_erase   = 1'b0;
    bad        = 1'b0;
    kind       = ER_SECTOR;
    whole_chip = 1'b0;
    if (evt) begin
      case (state)
        S_IDLE: if (hit1) nxt = S_U1;
        S_U1:   if (hit2) nxt = S_U2; else bad = 1'b1;
        S_U2: begin
          if (at_a1 && low == OP_PROG)       nxt = S_PROG;
          else if (at_a1 && low == OP_ERASE) nxt = S_E3;
          else                               bad = 1'b1;
        end
        S_PROG: begin
          nxt     = S_IDLE;
          go_prog = ~blocked;
        end
        S_E3: if (hit1) nxt = S_E4; else bad = 1'b1;
        S_E4: if (hit2) nxt = S_E5; else bad = 1'b1;
        S_E5: begin
          nxt = S_IDLE;
          if (low == OP_SECT) begin
            kind     = ER_SECTOR;
            go_erase = ~blocked;
          end else if (low == OP_BLK) begin
            kind     = ER_BLOCK;
            go_erase = ~blocked;
          end else if (low == OP_CHIP && at_a1) begin
            kind       = ER_CHIP;
            whole_chip = 1'b1;
            go_erase   = ~blocked;
          end else begin
            bad = 1'b1;
          end
        end
        default: nxt = S_IDLE;
      endcase
      if (bad) nxt = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state       <= S_IDLE;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      abort       <= 1'b0;
    end else begin
      state       <= nxt;
      prog_start  <= go_prog;
      erase_start <= go_erase;
      abort       <= bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_addr <= '0;
      erase_kind <= '0;
    end else begin
      if (go_prog) begin
        prog_addr <= evt_addr;
        prog_data <= evt_data;
      end
      if (go_erase) begin
        erase_addr <= evt_addr;
        erase_kind <= kind;
      end
    end
  end

  assert_single_op_R10: assert property (@(posedge clk) disable iff (rst)
    !(prog_start && erase_start));
  assert_prog_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);
  assert_erase_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);
  assert_abort_alone_R3: assert property (@(posedge clk) disable iff (rst)
    abort |-> !prog_start && !erase_start);
  assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> !prog_start && !erase_start && !abort);
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq #(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                MIN_PULSE = 3,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 20'h05555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 20'h02AAA,
  parameter logic [7:0]        KEY1      = 8'hAA,
  parameter logic [7:0]        KEY2      = 8'h55,
  parameter logic [7:0]        OP_PROG   = 8'hA0,
  parameter logic [7:0]        OP_ERASE  = 8'h80,
  parameter logic [7:0]        OP_SECT   = 8'h50,
  parameter logic [7:0]        OP_BLK    = 8'h30,
  parameter logic [7:0]        OP_CHIP   = 8'h10,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 20'hF8000,
  parameter int                BOOT_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp_n,
  input  logic              vdd_ok,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_start,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              abort
);
  logic              clear;
  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [DATA_W-1:0] evt_data;
  logic              whole_chip, blocked;

  assign clear = ~flash_rst_n;

  fcu_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_filter (
    .clk(clk), .rst(rst), .clear(clear),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .vdd_ok(vdd_ok),
    .addr(addr), .wdata(wdata),
    .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  fcu_boot_guard #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .BOOT_LOG2(BOOT_LOG2)
  ) u_guard (
    .addr(evt_addr), .wp_n(wp_n), .whole_chip(whole_chip), .blocked(blocked)
  );

  fcu_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2),
    .KEY1(KEY1), .KEY2(KEY2), .OP_PROG(OP_PROG), .OP_ERASE(OP_ERASE),
    .OP_SECT(OP_SECT), .OP_BLK(OP_BLK), .OP_CHIP(OP_CHIP)
  ) u_fsm (
    .clk(clk), .rst(rst), .clear(clear),
    .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data),
    .blocked(blocked), .whole_chip(whole_chip),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_kind(erase_kind),
    .erase_addr(erase_addr), .abort(abort)
  );

  localparam logic [ADDR_W-BOOT_LOG2-1:0] TAG = BOOT_BASE[ADDR_W-1:BOOT_LOG2];

  assert_boot_prog_guard_R5: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> ($past(wp_n) || prog_addr[ADDR_W-1:BOOT_LOG2] != TAG));
  assert_boot_erase_guard_R5: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> ($past(wp_n) ||
      (erase_kind != 2'd2 && erase_addr[ADDR_W-1:BOOT_LOG2] != TAG)));
endmodule

// File: tb/tb_flash_unlock_seq.sv
module tb_flash_unlock_seq;
  localparam int MINP = 3;

  logic        clk = 1'b0;
  logic        rst, flash_rst_n, ce_n, we_n, oe_n, wp_n, vdd_ok;
  logic [19:0] addr;
  logic [15:0] wdata;
  logic        prog_start, erase_start, abort;
  logic [19:0] prog_addr, erase_addr;
  logic [15:0] prog_data;
  logic [1:0]  erase_kind;

  int tests = 0, fails = 0;
  int n_prog = 0, n_erase = 0, n_abort = 0, wide_err = 0, both_err = 0;
  logic        prev_p = 1'b0, prev_e = 1'b0;
  logic [19:0] l_paddr, l_eaddr;
  logic [15:0] l_pdata;
  logic [1:0]  l_kind;

  always #10 clk = ~clk;

  flash_unlock_seq dut (
    .clk(clk), .rst(rst), .flash_rst_n(flash_rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .wp_n(wp_n), .vdd_ok(vdd_ok),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_kind(erase_kind),
    .erase_addr(erase_addr), .abort(abort)
  );

  always @(negedge clk) begin
    if (prog_start)  begin n_prog++;  l_paddr = prog_addr; l_pdata = prog_data; end
    if (erase_start) begin n_erase++; l_eaddr = erase_addr; l_kind = erase_kind; end
    if (abort) n_abort++;
    if ((prog_start && prev_p) || (erase_start && prev_e)) wide_err++;
    if (prog_start && erase_start) both_err++;
    prev_p = prog_start;
    prev_e = erase_start;
  end

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_blocked(input logic [19:0] a, input logic wp, input logic chip);
    return !wp && (a[19:15] == 5'h1F || chip);
  endfunction

  function automatic logic [15:0] cmd(input logic [7:0] b);
    return {8'($urandom), b};
  endfunction

  task automatic wr(input logic [19:0] a, input logic [15:0] d, input int w);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (w) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_inh(input logic [19:0] a, input logic [15:0] d, input int mode);
    @(negedge clk);
    addr = a; wdata = d;
    ce_n = (mode == 1); we_n = (mode == 3);
    oe_n = (mode != 0); vdd_ok = (mode != 2);
    repeat (MINP + 2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; vdd_ok = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(20'h05555, cmd(8'hAA), MINP);
    wr(20'h02AAA, cmd(8'h55), MINP);
  endtask

  task automatic do_prog(input logic [19:0] a, input logic [15:0] d);
    unlock();
    wr(20'h05555, cmd(8'hA0), MINP);
    wr(a, d, MINP);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_erase(input int k, input logic [19:0] a);
    unlock();
    wr(20'h05555, cmd(8'h80), MINP);
    unlock();
    case (k)
      0: wr(a, cmd(8'h50), MINP);
      1: wr(a, cmd(8'h30), MINP);
      default: wr(20'h05555, cmd(8'h10), MINP);
    endcase
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0, e0, a0;
    void'($urandom(32'h5EED1));
    rst = 1'b1; flash_rst_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    wp_n = 1'b1; vdd_ok = 1'b1; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 outputs", {prog_start, erase_start, abort, erase_kind}, 0);
    chk("R9 prog_addr", prog_addr, 0);

    // R1 + R4 program, random upper command bytes, wp low outside boot
    wp_n = 1'b0;
    p0 = n_prog;
    do_prog(20'h12345, 16'hBEEF);
    chk("R1 pulse count", n_prog - p0, 1);
    chk("R1 addr", l_paddr, 20'h12345);
    chk("R4 data", l_pdata, 16'hBEEF);

    // R2 erase kinds with wp high
    wp_n = 1'b1;
    e0 = n_erase;
    do_erase(0, 20'h40000);
    chk("R2 sector count", n_erase - e0, 1);
    chk("R2 sector kind", l_kind, 0);
    chk("R2 sector addr", l_eaddr, 20'h40000);
    do_erase(1, 20'hF8000);
    chk("R2 block kind", l_kind, 1);
    do_erase(2, 20'h0);
    chk("R2 chip kind", l_kind, 2);
    chk("R2 total", n_erase - e0, 3);

    // R5 protection
    wp_n = 1'b0;
    p0 = n_prog; e0 = n_erase; a0 = n_abort;
    do_prog(20'hF8000, 16'h1111);
    do_prog(20'hFFFFF, 16'h2222);
    do_erase(2, 20'h0);
    do_erase(0, 20'hFC000);
    chk("R5 blocked prog", n_prog - p0, 0);
    chk("R5 blocked erase", n_erase - e0, 0);
    chk("R5 no abort", n_abort - a0, 0);
    do_prog(20'hF7FFF, 16'h3333);
    chk("R5 edge below boot", n_prog - p0, 1);
    wp_n = 1'b1;
    do_prog(20'hFFFFF, 16'h4444);
    chk("R5 wp high prog", n_prog - p0, 2);
    chk("R5 wp high addr", l_paddr, 20'hFFFFF);

    // R3 mismatch
    a0 = n_abort; p0 = n_prog;
    unlock();
    wr(20'h05555, cmd(8'h77), MINP);
    repeat (2) @(negedge clk);
    chk("R3 abort", n_abort - a0, 1);
    wr(20'h01234, 16'h5678, MINP);
    repeat (2) @(negedge clk);
    chk("R3 back to idle", n_prog - p0, 0);
    chk("R3 idle mismatch quiet", n_abort - a0, 1);
    wr(20'h05555, cmd(8'hAA), MINP);
    wr(20'h05555, cmd(8'hAA), MINP);
    repeat (2) @(negedge clk);
    chk("R3 second step abort", n_abort - a0, 2);

    // R8 glitch filter and long strobe
    p0 = n_prog; a0 = n_abort;
    wr(20'h05555, cmd(8'hAA), MINP);
    wr(20'h00001, 16'h0000, MINP - 1);
    wr(20'h02AAA, cmd(8'h55), MINP);
    wr(20'h05555, cmd(8'hA0), MINP + 6);
    wr(20'h0ABCD, 16'h9876, MINP);
    repeat (2) @(negedge clk);
    chk("R8 short ignored, long once", n_prog - p0, 1);
    chk("R8 addr", l_paddr, 20'h0ABCD);
    chk("R8 no abort", n_abort - a0, 0);

    // R6 inhibits
    p0 = n_prog; a0 = n_abort;
    unlock();
    for (int m = 0; m < 4; m++) wr_inh(20'h00777, 16'h0000, m);
    wr(20'h05555, cmd(8'hA0), MINP);
    wr(20'h00042, 16'hCAFE, MINP);
    repeat (2) @(negedge clk);
    chk("R6 inhibited writes ignored", n_prog - p0, 1);
    chk("R6 no abort", n_abort - a0, 0);

    // R7 reset mid-sequence
    p0 = n_prog; a0 = n_abort;
    unlock();
    wr(20'h05555, cmd(8'hA0), MINP);
    @(negedge clk); flash_rst_n = 1'b0;
    @(negedge clk); flash_rst_n = 1'b1;
    wr(20'h00055, 16'h1234, MINP);
    repeat (2) @(negedge clk);
    chk("R7 partial abandoned", n_prog - p0, 0);
    chk("R7 no abort", n_abort - a0, 0);
    // R7 reset coinciding with completing write
    unlock();
    wr(20'h05555, cmd(8'hA0), MINP);
    @(negedge clk);
    addr = 20'h00066; wdata = 16'h4321; ce_n = 1'b0; we_n = 1'b0;
    repeat (MINP) @(negedge clk);
    flash_rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); flash_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 same-cycle reset", n_prog - p0, 0);
    do_prog(20'h00077, 16'h7777);
    chk("R7 restart works", n_prog - p0, 1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int k;
      logic wp;
      logic [19:0] a;
      logic [15:0] d;
      logic blk;
      k = $urandom_range(0, 4);
      wp = 1'($urandom_range(0, 1));
      a = 20'($urandom);
      if ($urandom_range(0, 2) == 0) a[19:15] = 5'h1F;
      d = 16'($urandom);
      wp_n = wp;
      p0 = n_prog; e0 = n_erase; a0 = n_abort;
      blk = exp_blocked(a, wp, k == 3);
      if (k == 0) begin
        do_prog(a, d);
        chk("R1 rand prog", n_prog - p0, blk ? 0 : 1);
        if (!blk) begin
          chk("R1 rand addr", l_paddr, a);
          chk("R1 rand data", l_pdata, d);
        end
      end else if (k == 4) begin
        unlock();
        wr(20'h05555, cmd(8'h33), MINP);
        repeat (2) @(negedge clk);
        chk("R3 rand abort", n_abort - a0, 1);
      end else begin
        do_erase(k - 1, a);
        chk("R2 rand erase", n_erase - e0, blk ? 0 : 1);
        if (!blk) chk("R2 rand kind", l_kind, k - 1);
        chk("R5 rand no abort", n_abort - a0, 0);
      end
    end

    chk("R10 pulse width", wide_err, 0);
    chk("R10 exclusive", both_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule